// File: doc/BRIEF.md
# MMU and Exception Register File

This block holds the control and status words that a processor core keeps for its memory management unit and its exception logic. The words are the MMU control word, the high and low halves of the page-table entry being built, the page-table assist word, the translation table base, the faulting address, the trap code, the exception event code and the interrupt event code. Software reaches them through a small register bus. A request channel with valid/ready carries each read or write into the block. A response channel with valid/ready carries back one beat per accepted request: the read data, or zero after a write, together with an error bit.

Some writes have side effects that the TLB next to this block consumes. A write to the MMU control word with its invalidate bit set produces a one-cycle invalidate pulse. The bit itself is never stored. A write to the page-table-entry high word that changes the address-space ID in its low 8 bits produces a one-cycle flush pulse. Several words keep only part of what is written. An access to an offset that holds no register raises a one-cycle error pulse and sets the error bit of the response.

Back-pressure works as follows. The response channel has one slot. While that slot holds a beat that the consumer has not taken, `req_ready` is low. A held beat does not change until `rsp_ready` takes it. A new request can be accepted in the same cycle that the old beat is taken.

Top module: `mmu_exc_regfile`

## Requirements
- R1: After reset every register reads as zero.
- R2: Byte offsets 0x08 (page-table-entry low), 0x10 (table base) and 0x14 (fault address) store all 32 written bits.
- R3: Offset 0x0C (page-table assist) keeps only bits 3:0 of a write; bits 31:4 read as zero.
- R4: Offsets 0x18 (trap code), 0x1C (exception event) and 0x20 (interrupt event) keep only bits 10:0 of a write; bits 31:11 read as zero.
- R5: A write to offset 0x00 (MMU control) with bit 2 set drives `tlb_inval_o` high during the cycle in which the write is accepted and in no other cycle. Bit 2 always reads back as 0, and the other 31 bits are stored as written.
- R6: A write to offset 0x04 (page-table-entry high) stores all 32 bits. It drives `tlb_flush_o` high during its accept cycle only if written bits 7:0 differ from the stored bits 7:0. An equal value gives no pulse.
- R7: An offset that is misaligned (bits 1:0 not zero) or above 0x20 is unmapped. A write to it changes no register. A read from it returns zero. Either access returns `rsp_err`=1 and drives `bus_err_o` high in its accept cycle.
- R8: While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low and `rsp_rdata` and `rsp_err` hold their values.
- R9: Every request accepted at a clock edge produces a response beat with `rsp_valid` high from that edge on. Writes to mapped offsets return data 0 and `rsp_err` 0.
- R10: Reads and writes to other offsets never raise `tlb_inval_o` or `tlb_flush_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response beat present |
| rsp_ready | input | 1 | Consumer takes the response beat |
| rsp_rdata | output | 32 | Read data (zero for writes and errors) |
| rsp_err | output | 1 | Access hit an unmapped offset |
| tlb_inval_o | output | 1 | One-cycle TLB invalidate request |
| tlb_flush_o | output | 1 | One-cycle TLB flush on address-space change |
| bus_err_o | output | 1 | One-cycle pulse on an unmapped access |

## Verification
The hardest case to reach is a page-table-entry high write whose low byte equals the stored address-space ID. Random data almost never produces it, so the stimulus builds such writes on purpose from the bench's own model of the stored value and mixes them with random ones. A second case is a request that arrives while a response is stalled. The bench holds `rsp_ready` low for a random number of cycles before it takes each beat, so both back-pressure and data hold are exercised throughout.

// File: rtl/mmu_regs_pkg.sv
package mmu_regs_pkg;

  localparam int DATA_W = 32;
  localparam int NREG   = 9;
  localparam int IDX_W  = $clog2(NREG);

  typedef enum logic [IDX_W-1:0] {
    RG_CTRL  = 4'd0,
    RG_PTEHI = 4'd1,
    RG_PTELO = 4'd2,
    RG_ASSIST= 4'd3,
    RG_TTB   = 4'd4,
    RG_FADDR = 4'd5,
    RG_TRAP  = 4'd6,
    RG_EXCEV = 4'd7,
    RG_IRQEV = 4'd8
  } reg_id_e;

  localparam int ASSIST_W = 4;
  localparam int CODE_W   = 11;

  // Bits kept on a write, per register slot.
  function automatic logic [DATA_W-1:0] keep_mask(input int idx);
    logic [DATA_W-1:0] m;
    case (idx)
      int'(RG_ASSIST): m = DATA_W'((64'd1 << ASSIST_W) - 64'd1);
      int'(RG_TRAP),
      int'(RG_EXCEV),
      int'(RG_IRQEV):  m = DATA_W'((64'd1 << CODE_W) - 64'd1);
      default:         m = '1;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/mmu_reg_decode.sv
module mmu_reg_decode
  import mmu_regs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;

  always_comb begin
    word = addr[ADDR_W-1:2];
    hit  = (addr[1:0] == 2'b00) && (int'(word) < NREG);
    idx  = hit ? word[IDX_W-1:0] : '0;
  end
endmodule

// File: rtl/mmu_reg_bank.sv
module mmu_reg_bank
  import mmu_regs_pkg::*;
#(
  parameter int INVAL_BIT = 2,
  parameter int ASID_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic [ASID_W-1:0] asid_q,
  output logic [DATA_W-1:0] ctrl_q
);
  logic [DATA_W-1:0] slot_q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_slot
    localparam logic [DATA_W-1:0] INVAL_CLR =
      (i == int'(RG_CTRL)) ? ~(DATA_W'(1) << INVAL_BIT) : '1;
    localparam logic [DATA_W-1:0] KEEP = keep_mask(i) & INVAL_CLR;

    logic [DATA_W-1:0] r_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        r_q <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(i))) begin
        r_q <= wr_data & KEEP;
      end
    end

    assign slot_q[i] = r_q;
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NREG; k++) begin
      if (rd_idx == IDX_W'(k)) rd_data = slot_q[k];
    end
  end

  assign asid_q = slot_q[int'(RG_PTEHI)][ASID_W-1:0];
  assign ctrl_q = slot_q[int'(RG_CTRL)];
endmodule

// File: rtl/mmu_tlb_pulse.sv
module mmu_tlb_pulse
  import mmu_regs_pkg::*;
#(
  parameter int INVAL_BIT = 2,
  parameter int ASID_W    = 8
) (
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ASID_W-1:0] asid_q,
  output logic              inval,
  output logic              flush
);
  always_comb begin
    inval = wr_en && (wr_idx == RG_CTRL) && wr_data[INVAL_BIT];
    flush = wr_en && (wr_idx == RG_PTEHI) &&
            (wr_data[ASID_W-1:0] != asid_q);
  end
endmodule

// File: rtl/mmu_exc_regfile.sv
module mmu_exc_regfile
  import mmu_regs_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int INVAL_BIT = 2,
  parameter int ASID_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              tlb_inval_o,
  output logic              tlb_flush_o,
  output logic              bus_err_o
);
  logic              hit;
  logic [IDX_W-1:0]  idx;
  logic              accept;
  logic              wr_en;
  logic [DATA_W-1:0] rd_data;
  logic [ASID_W-1:0] asid_q;
  logic [DATA_W-1:0] ctrl_q;

  mmu_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (req_addr),
    .hit  (hit),
    .idx  (idx)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign wr_en     = accept && req_write && hit;
  assign bus_err_o = accept && !hit;

  mmu_reg_bank #(.INVAL_BIT(INVAL_BIT), .ASID_W(ASID_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (idx),
    .wr_data (req_wdata),
    .rd_idx  (idx),
    .rd_data (rd_data),
    .asid_q  (asid_q),
    .ctrl_q  (ctrl_q)
  );

  mmu_tlb_pulse #(.INVAL_BIT(INVAL_BIT), .ASID_W(ASID_W)) u_pulse (
    .wr_en   (wr_en),
    .wr_idx  (idx),
    .wr_data (req_wdata),
    .asid_q  (asid_q),
    .inval   (tlb_inval_o),
    .flush   (tlb_flush_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= (!req_write && hit) ? rd_data : '0;
      rsp_err   <= !hit;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R8
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_err));

  // R8
  req_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);

  // R9
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);

  // R7
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err_o |-> !tlb_inval_o && !tlb_flush_o);

  // R6
  flush_asid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_flush_o |=> asid_q != $past(asid_q));

  // R5
  inval_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_inval_o |=> !ctrl_q[INVAL_BIT]);

  // R10
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tlb_inval_o, tlb_flush_o}));
endmodule

// File: tb/tb_mmu_exc_regfile.sv
`timescale 1ns/1ps
module tb_mmu_exc_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_rdata;
  logic        rsp_err;
  logic        tlb_inval_o, tlb_flush_o, bus_err_o;

  int checks = 0;
  int fails  = 0;
  logic [31:0] model [9];

  always #5 clk = ~clk;

  mmu_exc_regfile dut (
    .clk, .rst_n, .req_valid, .req_ready, .req_write, .req_addr, .req_wdata,
    .rsp_valid, .rsp_ready, .rsp_rdata, .rsp_err,
    .tlb_inval_o, .tlb_flush_o, .bus_err_o
  );

  function automatic logic [31:0] kept(int i, logic [31:0] d);
    case (i)
      0: return d & 32'hFFFF_FFFB;  // R5
      3: return d & 32'h0000_000F;  // R3
      6, 7, 8: return d & 32'h0000_07FF;  // R4
      default: return d;  // R2 R6
    endcase
  endfunction

  function automatic string tag_of(int i);
    case (i)
      0: return "R5";
      1: return "R6";
      3: return "R3";
      6, 7, 8: return "R4";
      default: return "R2";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic txn(input logic wr, input logic [7:0] a, input logic [31:0] d,
                     input int stall);
    bit hit;
    int idx;
    logic [31:0] exp_rd;
    logic [31:0] held_d;
    logic held_e;
    hit = (a[1:0] == 2'b00) && (a <= 8'h20);
    idx = a >> 2;
    exp_rd = (!wr && hit) ? model[idx] : 32'h0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    #1;
    chk("R9", {31'b0, req_ready}, 32'h1);
    chk("R5", {31'b0, tlb_inval_o}, {31'b0, wr && hit && idx == 0 && d[2]});
    chk("R6", {31'b0, tlb_flush_o},
        {31'b0, wr && hit && idx == 1 && (d[7:0] != model[1][7:0])});
    chk("R7", {31'b0, bus_err_o}, {31'b0, !hit});
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9", {31'b0, rsp_valid}, 32'h1);
    held_d = rsp_rdata; held_e = rsp_err;
    for (int s = 0; s < stall; s++) begin
      req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h00;
      #1;
      chk("R8", {31'b0, req_ready}, 32'h0);
      chk("R10", {30'b0, tlb_inval_o, tlb_flush_o}, 32'h0);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R8", {rsp_rdata[30:0] ^ held_d[30:0], rsp_err ^ held_e}, 32'h0);
      chk("R8", {31'b0, rsp_valid}, 32'h1);
    end
    rsp_ready = 1'b1;
    #1;
    chk(hit ? (wr ? "R9" : tag_of(idx)) : "R7", rsp_rdata, exp_rd);
    chk(hit ? "R9" : "R7", {31'b0, rsp_err}, {31'b0, !hit});
    @(posedge clk);
    @(negedge clk);
    rsp_ready = 1'b0;
    if (wr && hit) model[idx] = kept(idx, d);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 9; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values
    for (int i = 0; i < 9; i++) begin
      txn(1'b0, 8'(i * 4), 32'h0, 0);
      chk("R1", model[i], 32'h0);
    end
    // R5: invalidate bit with other bits
    txn(1'b1, 8'h00, 32'hFFFF_FFFF, 1);
    txn(1'b0, 8'h00, 32'h0, 0);
    txn(1'b1, 8'h00, 32'h0000_0011, 0);
    // R6: ASID change, then same ASID
    txn(1'b1, 8'h04, 32'h1234_00A5, 0);
    txn(1'b1, 8'h04, 32'hDEAD_BEA5, 2);
    txn(1'b0, 8'h04, 32'h0, 0);
    // R2 R3 R4
    txn(1'b1, 8'h08, 32'hCAFE_F00D, 0);
    txn(1'b1, 8'h0C, 32'hFFFF_FFFF, 0);
    txn(1'b1, 8'h18, 32'hFFFF_FFFF, 0);
    txn(1'b1, 8'h20, 32'hABCD_EF12, 0);
    // R7: unmapped writes change nothing, reads give zero
    txn(1'b1, 8'h24, 32'hFFFF_FFFF, 0);
    txn(1'b1, 8'h09, 32'hFFFF_FFFF, 1);
    txn(1'b0, 8'hFC, 32'h0, 0);
    for (int i = 0; i < 9; i++) txn(1'b0, 8'(i * 4), 32'h0, 0);
    // random mix
    for (int n = 0; n < 400; n++) begin
      int pick;
      logic [7:0] a;
      logic [31:0] d;
      pick = $urandom_range(0, 9);
      a = (pick < 8) ? 8'($urandom_range(0, 8) * 4) : 8'($urandom_range(0, 255));
      d = $urandom();
      if (a == 8'h04 && $urandom_range(0, 1) == 1) d[7:0] = model[1][7:0];
      txn($urandom_range(0, 1) == 1, a, d, $urandom_range(0, 3));
    end
    finish_run();
  end
endmodule